// File: doc/BRIEF.md
# Dithered Fractional Clock Divider

This block derives a slower clock, typically an audio serial bit clock, from a fast source clock. The division ratio is a 12-bit whole part plus a 12-bit fraction counted in steps of 1/4096. Each output period lasts either the whole divisor or one source cycle more. A first-order phase accumulator with modulus 4096 makes that choice again for every period, so the long-term mean ratio equals whole + fraction/4096.

Software-style configuration reaches the block as a 24-bit divisor word, written with a one-cycle strobe, and a 2-bit shaping-order input. Shaping order zero ignores the fraction and gives clean integer division with no period dithering. Any non-zero order runs the first-order accumulator. Dropping the enable or writing a new divisor clears the accumulator and restarts the period count. While stopped, the output rests low.

Top module: `frac_clk_div`

## Requirements
- R1: A divisor write (`div_we` high for one cycle) captures the whole divisor from `div_wdata[23:12]` and the fraction from `div_wdata[11:0]`.
- R2: With the shaping order non-zero, every output period (rising edge to rising edge of `clk_out`) lasts either D or D+1 source cycles, where D is the effective whole divisor.
- R3: With the shaping order non-zero and fraction F, the 4096 periods that follow the first period after a restart contain exactly F periods of D+1 cycles.
- R4: When the fraction is zero, every period lasts exactly D cycles.
- R5: Shaping order 0 ignores the fraction: every period lasts exactly D cycles, whatever the fraction field holds.
- R6: In a period of L cycles, `clk_out` is high for the first floor(L/2) cycles and low for the remaining cycles.
- R7: A whole divisor of 0 or 1 acts as 2.
- R8: While `enable` is low, `clk_out` stays low. After `enable` rises, the first period lasts exactly D cycles, because the accumulator has been cleared.
- R9: A divisor write during operation abandons the current period. The next period starts from a cleared accumulator with the new D.
- R10: After reset, `clk_out` is low.
- R11: Shaping orders 2 and 3 behave exactly as order 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the divider; low holds it cleared |
| div_we | input | 1 | One-cycle write strobe for the divisor word |
| div_wdata | input | 24 | Divisor word: whole part [23:12], fraction [11:0] |
| shaping_order | input | 2 | 0 = integer only, non-zero = first-order dithering |
| clk_out | output | 1 | Divided clock |

## Verification
The hardest property to reach from the ports is the exact count of long periods over a complete accumulator cycle. Confirming it takes 4096 back-to-back periods measured without a gap, and each period is hundreds of source cycles long at realistic divisors. The stimulus therefore pairs a small whole divisor (2 to 4) with random and directed fractions, so that a full cycle fits in about ten thousand source cycles. A realistic large divisor is also run, but over a short window only. Restarts use a fraction of 4095, which makes almost every period long. A first period of exactly D cycles after an enable toggle or a write then shows that the accumulator was cleared.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

   typedef enum logic [1:0] {
      SHAPE_INT   = 2'd0,
      SHAPE_ORD1  = 2'd1,
      SHAPE_RSV2  = 2'd2,
      SHAPE_RSV3  = 2'd3
   } shape_e;

   // Any non-zero order runs the first-order accumulator.
   function automatic logic shape_dithers(input shape_e mode);
      return mode != SHAPE_INT;
   endfunction

endpackage

// File: rtl/fcd_divreg.sv
module fcd_divreg
   import fcd_pkg::*;
#(
   parameter int INT_W   = 12,
   parameter int FRAC_W  = 12,
   parameter int MIN_DIV = 2,
   parameter bit FRAC_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr,
   input  logic [INT_W+FRAC_W-1:0] wdata,
   input  logic [1:0]              order,
   output logic [INT_W-1:0]        divi_eff,
   output logic [FRAC_W-1:0]       divf_eff
);

   localparam int WORD_W = INT_W + FRAC_W;

   generate
      if (MIN_DIV < 2 || MIN_DIV >= (1 << INT_W)) begin : g_bad_min
         $error("fcd_divreg: MIN_DIV out of range");
      end
   endgenerate

   logic [INT_W-1:0]  int_q;
   logic [FRAC_W-1:0] frac_q;
   shape_e            mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_q  <= '0;
         frac_q <= '0;
      end else if (wr) begin
         int_q  <= wdata[WORD_W-1:FRAC_W];
         frac_q <= wdata[FRAC_W-1:0];
      end
   end

   assign mode     = shape_e'(order);
   assign divi_eff = (int_q < INT_W'(MIN_DIV)) ? INT_W'(MIN_DIV) : int_q;

   generate
      if (FRAC_EN) begin : g_frac
         assign divf_eff = shape_dithers(mode) ? frac_q : '0;
      end else begin : g_int_only
         assign divf_eff = '0;
      end
   endgenerate

   // R1: the write lands in the right fields
   a_r1_capture : assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (int_q == $past(wdata[WORD_W-1:FRAC_W])) &&
             (frac_q == $past(wdata[FRAC_W-1:0])));

   // R7: divisor never below the floor seen by the counter
   a_r7_min_div : assert property (@(posedge clk) disable iff (!rst_n)
      divi_eff >= INT_W'(MIN_DIV));

endmodule

// File: rtl/fcd_sigma.sv
module fcd_sigma #(
   parameter int FRAC_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  logic [FRAC_W-1:0] addend,
   output logic              carry_q
);

   generate
      if (FRAC_W < 1) begin : g_bad_w
         $error("fcd_sigma: FRAC_W must be positive");
      end
   endgenerate

   logic [FRAC_W-1:0] acc;
   logic [FRAC_W:0]   sum;

   assign sum = {1'b0, acc} + {1'b0, addend};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         carry_q <= 1'b0;
      end else if (clear) begin
         acc     <= '0;
         carry_q <= 1'b0;
      end else if (step) begin
         acc     <= sum[FRAC_W-1:0];
         carry_q <= sum[FRAC_W];
      end
   end

   // R4: a zero addend can never ask for a long period
   a_r4_no_carry_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear && addend == '0) |=> !carry_q);

   // R8: a cleared accumulator starts with a short period
   a_r8_clear_short : assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !carry_q);

endmodule

// File: rtl/fcd_period.sv
module fcd_period #(
   parameter int LEN_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [LEN_W-1:0] len,
   output logic             wrap,
   output logic             clk_out
);

   generate
      if (LEN_W < 2) begin : g_bad_w
         $error("fcd_period: LEN_W must be at least 2");
      end
   endgenerate

   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] hi_len;
   logic [LEN_W-1:0] last;

   assign hi_len = len >> 1;
   assign last   = len - LEN_W'(1);
   assign wrap   = (cnt >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         clk_out <= 1'b0;
      end else if (clear) begin
         cnt     <= '0;
         clk_out <= 1'b0;
      end else begin
         clk_out <= (cnt < hi_len);
         cnt     <= wrap ? '0 : cnt + LEN_W'(1);
      end
   end

   // R6: high phase opens each period
   a_r6_rise_at_start : assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && cnt == '0) |=> clk_out);

   // R6: low phase closes each period
   a_r6_low_at_end : assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && wrap) |=> !clk_out);

   // R10 / R8: stopped divider rests low
   a_r10_clear_low : assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !clk_out);

   // R2: the count never runs past the chosen length
   a_r2_cnt_bound : assert property (@(posedge clk) disable iff (!rst_n)
      cnt < len);

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
   parameter int INT_W   = 12,
   parameter int FRAC_W  = 12,
   parameter int MIN_DIV = 2,
   parameter bit FRAC_EN = 1'b1
) (
   input  logic                    clk_src,
   input  logic                    rst_n,
   input  logic                    enable,
   input  logic                    div_we,
   input  logic [INT_W+FRAC_W-1:0] div_wdata,
   input  logic [1:0]              shaping_order,
   output logic                    clk_out
);

   localparam int LEN_W = INT_W + 1;

   generate
      if (INT_W < 2 || FRAC_W < 1) begin : g_bad_param
         $error("frac_clk_div: field widths too small");
      end
   endgenerate

   logic [INT_W-1:0]  divi_eff;
   logic [FRAC_W-1:0] divf_eff;
   logic              restart;
   logic              carry;
   logic              wrap;
   logic [LEN_W-1:0]  len;

   assign restart = !enable || div_we;
   assign len     = {1'b0, divi_eff} + {{(LEN_W-1){1'b0}}, carry};

   fcd_divreg #(
      .INT_W   (INT_W),
      .FRAC_W  (FRAC_W),
      .MIN_DIV (MIN_DIV),
      .FRAC_EN (FRAC_EN)
   ) u_divreg (
      .clk      (clk_src),
      .rst_n    (rst_n),
      .wr       (div_we),
      .wdata    (div_wdata),
      .order    (shaping_order),
      .divi_eff (divi_eff),
      .divf_eff (divf_eff)
   );

   fcd_sigma #(
      .FRAC_W (FRAC_W)
   ) u_sigma (
      .clk     (clk_src),
      .rst_n   (rst_n),
      .clear   (restart),
      .step    (wrap),
      .addend  (divf_eff),
      .carry_q (carry)
   );

   fcd_period #(
      .LEN_W (LEN_W)
   ) u_period (
      .clk     (clk_src),
      .rst_n   (rst_n),
      .clear   (restart),
      .len     (len),
      .wrap    (wrap),
      .clk_out (clk_out)
   );

   // R8: disabled divider keeps its output low
   a_r8_idle_low : assert property (@(posedge clk_src) disable iff (!rst_n)
      !enable |=> !clk_out);

endmodule

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        div_we = 1'b0;
   logic [23:0] div_wdata = '0;
   logic [1:0]  shaping_order = 2'd1;
   logic        clk_out;

   int checks = 0;
   int fails  = 0;
   int lens [0:4200];
   int highs[0:4200];

   always #4 clk = ~clk;

   frac_clk_div u_frac_clk_div (
      .clk_src       (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .div_we        (div_we),
      .div_wdata     (div_wdata),
      .shaping_order (shaping_order),
      .clk_out       (clk_out)
   );

   function automatic int exp_div(input int divi);
      return (divi < 2) ? 2 : divi;
   endfunction

   function automatic int exp_frac(input int divf, input int order);
      return (order == 0) ? 0 : divf;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Record n+1 periods, starting at the next rising edge of clk_out.
   task automatic measure(input int n);
      logic prev;
      logic rise;
      int   k = 0;
      int   c;
      int   h;
      prev = clk_out;
      do begin
         @(negedge clk);
         rise = clk_out && !prev;
         prev = clk_out;
      end while (!rise);
      c = 1;
      h = 1;
      while (k <= n) begin
         @(negedge clk);
         if (clk_out && !prev) begin
            lens[k]  = c;
            highs[k] = h;
            k++;
            c = 1;
            h = 1;
         end else begin
            c++;
            if (clk_out) h++;
         end
         prev = clk_out;
      end
   endtask

   task automatic write_div(input int divi, input int divf);
      @(negedge clk);
      div_we    = 1'b1;
      div_wdata = {divi[11:0], divf[11:0]};
      @(negedge clk);
      div_we    = 1'b0;
   endtask

   // Evaluate periods 0..n against divisor, fraction and order.
   task automatic judge(input int divi, input int divf, input int order,
                        input int n, input string first_req, input string len_req);
      int d = exp_div(divi);
      int f = exp_frac(divf, order);
      int bad = 0;
      int longs = 0;
      int hbad = 0;
      chk(lens[0] == d, first_req, lens[0], d);
      for (int k = 1; k <= n; k++) begin
         if (lens[k] == d + 1) longs++;
         else if (lens[k] != d) bad++;
         if (highs[k] != lens[k] / 2) hbad++;
      end
      chk(bad == 0, len_req, bad, 0);
      chk(hbad == 0, "R6 high time", hbad, 0);
      if (n == 4096) chk(longs == f, "R3 long count", longs, f);
      else if (f == 0) chk(longs == 0, len_req, longs, 0);
   endtask

   task automatic run_cfg(input int divi, input int divf, input int order,
                          input int n, input string len_req);
      enable = 1'b0;
      shaping_order = order[1:0];
      write_div(divi, divf);
      enable = 1'b1;
      measure(n);
      judge(divi, divf, order, n, "R8 first period", len_req);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stim
      int d;
      int f;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(clk_out == 1'b0, "R10 reset low", clk_out, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(clk_out == 1'b0, "R8 idle low", clk_out, 0);

      // R1, R2, R3: directed fraction over a full accumulator cycle
      run_cfg(3, 577, 1, 4096, "R2 length set");
      // R4: zero fraction
      run_cfg(5, 0, 1, 200, "R4 integer periods");
      // R5: integer mode ignores fraction
      run_cfg(4, 1000, 0, 300, "R5 fraction ignored");
      // R7: divisor clamp
      run_cfg(0, 0, 1, 50, "R7 clamp zero");
      run_cfg(1, 2048, 1, 4096, "R7 clamp one");
      // R11: reserved orders act as first order
      run_cfg(2, 1234, 2, 4096, "R11 order two");
      run_cfg(3, 3001, 3, 4096, "R11 order three");
      // random first-order runs (R2, R3)
      for (int i = 0; i < 2; i++) begin
         d = $urandom_range(4, 2);
         f = $urandom_range(4095, 0);
         run_cfg(d, f, 1, 4096, "R2 random lengths");
      end
      // R1: large divisor, short window
      run_cfg(244, 577, 1, 30, "R1 R2 large divisor");

      // R8: enable drop clears the accumulator (fraction 4095 makes most periods long)
      run_cfg(3, 4095, 1, 40, "R2 dense fraction");
      @(negedge clk);
      enable = 1'b0;
      repeat (3) @(negedge clk);
      chk(clk_out == 1'b0, "R8 low while disabled", clk_out, 0);
      enable = 1'b1;
      measure(10);
      chk(lens[0] == 3, "R8 first after re-enable", lens[0], 3);

      // R9: write while running restarts with the new divisor
      repeat (7) @(negedge clk);
      write_div(6, 4095);
      measure(10);
      judge(6, 4095, 1, 10, "R9 first after write", "R9 lengths after write");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule